// File: doc/BRIEF.md
# Binary Pixel Array with Per-Cell Image Store

This block is the digital part of a grid of binary image cells. Every cell keeps four one-bit image planes and an intermediate latch. All cells share one two-input logic gate whose truth table is broadcast to every cell. A row of shared column lines carries pixels in both directions. Images enter one row per cycle. Images leave the same way. Parallel operations act on every cell in one cycle: storing an optical sample, storing an analog evolution result, storing the gate output, or moving a bit through the latch.

A single command port selects the operation, the target plane, the write source, the row and the truth table. Each command is taken with a valid/ready handshake. The block raises a one-cycle done pulse when the command has finished. The optical sample and the evolution result reach each cell as plain digital inputs, with one bit per cell. Cell (r, c) uses bit r*COLS+c of each of these inputs.

Top module: `pixmem_array`

## Requirements
- R1: Each cell holds four planes, numbered 0 to 3 and chosen by cmd_loc. A write command changes only the chosen plane, and only in the cells it addresses.
- R2: After reset, every plane and every latch holds 0, cmd_ready is 1, and done and col_oe are 0.
- R3: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. cmd_ready then stays 0 while the command executes. Commands on op 0 and op 1 execute for ROWS cycles; every other op executes for one cycle. In the cycle after the last execution cycle, done is 1 for exactly one cycle and cmd_ready is 1 again.
- R4: Image load (op 0) writes col_in into the chosen plane of row k, using the value sampled at the end of execution cycle k.
- R5: Image read (op 1) drives col_oe=1 in every execution cycle. In execution cycle k, col_out[c] shows the chosen plane of cell (k, c).
- R6: Row load (op 2) and row read (op 3) act on row cmd_row only. A row index of ROWS or more writes nothing and reads 0.
- R7: Parallel write (op 4) writes the chosen plane in every cell. The source is set by cmd_src: 0 selects the optical bit, 1 selects col_in[c], 2 selects the evolution bit (1 = positive state), and 3 selects the gate output.
- R8: The gate output of a cell is cmd_lut[{plane1, plane0}], using that cell's own planes 1 and 0.
- R9: Latch capture (op 5) acts on every cell. If cmd_src[1] is 1, the latch takes the constant cmd_src[0] (1 for +1, 0 for -1). Otherwise the latch takes the chosen plane. Latch write (op 6) copies the latch into the chosen plane of every cell.
- R10: col_oe is 1 only during the execution cycles of op 1 and op 3, and no plane or latch changes in those cycles. col_out is 0 whenever col_oe is 0.
- R11: Op 7 changes nothing and completes like any one-cycle command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, able to take a command |
| cmd_op | input | 3 | Operation code (0 to 7) |
| cmd_loc | input | 2 | Target or source plane |
| cmd_src | input | 2 | Write source, or latch constant selection |
| cmd_row | input | $clog2(ROWS) | Row for single-row ops |
| cmd_lut | input | 4 | Gate truth table |
| col_in | input | COLS | Column lines driven from outside |
| col_out | output | COLS | Column lines driven by the array |
| col_oe | output | 1 | Array drives the column lines |
| opt_in | input | ROWS*COLS | Optical sample, one bit per cell |
| evo_in | input | ROWS*COLS | Evolution result, one bit per cell |
| done | output | 1 | Completion pulse |

## Verification
The bench builds a 5 x 3 array. With a row count that is not a power of two, row indices 5 to 7 are legal encodings that address no row, so the out-of-range case of R6 can be driven. With three columns, each row carries distinct patterns. Because image transfers last only five cycles, every plane can be read back after each operation. The behavioural model then checks each plane against its own bookkeeping on every cycle.

// File: rtl/pixmem_pkg.sv
// Shared definitions for the binary pixel array.
// Assumes: exactly four planes per cell; the gate always reads planes 0 and 1.
package pixmem_pkg;
    localparam int LOCS = 4;
    localparam int LW   = 2;

    typedef enum logic [2:0] {
        OP_IMG_LOAD  = 3'd0,
        OP_IMG_READ  = 3'd1,
        OP_ROW_LOAD  = 3'd2,
        OP_ROW_READ  = 3'd3,
        OP_PAR_WRITE = 3'd4,
        OP_LATCH     = 3'd5,
        OP_LATCH_WR  = 3'd6,
        OP_NOP       = 3'd7
    } pm_op_e;

    typedef enum logic [1:0] {
        SRC_OPT  = 2'd0,
        SRC_COL  = 2'd1,
        SRC_EVO  = 2'd2,
        SRC_GATE = 2'd3
    } pm_src_e;
endpackage

// File: rtl/pixmem_cell.sv
// One pixel cell: four planes, a transfer latch, the broadcast gate and the source mux.
// Assumes: LOCS >= 2; loc_sel is one-hot; every enable is qualified by row_en.
module pixmem_cell
    import pixmem_pkg::*;
#(
    parameter int NLOC = LOCS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            row_en,
    input  logic            wr_en,
    input  logic            lat_cap,
    input  logic            lat_wr,
    input  logic [NLOC-1:0] loc_sel,
    input  pm_src_e         src,
    input  logic            lat_const,
    input  logic            lat_val,
    input  logic [3:0]      lut,
    input  logic            opt_bit,
    input  logic            evo_bit,
    input  logic            col_bit,
    output logic            rd_bit
);
    logic [NLOC-1:0] mem;
    logic            lat;
    logic            gate_out;
    logic            wdata;

    // The gate looks up its truth table with planes 1 and 0 as the index.
    assign gate_out = lut[{mem[1], mem[0]}];

    // The read port returns the selected plane.
    assign rd_bit = |(mem & loc_sel);

    // The write-source mux.
    always_comb begin
        case (src)
            SRC_OPT:  wdata = opt_bit;
            SRC_COL:  wdata = col_bit;
            SRC_EVO:  wdata = evo_bit;
            default:  wdata = gate_out;
        endcase
    end

    // Plane and latch storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
            lat <= 1'b0;
        end else if (row_en) begin
            if (wr_en)
                mem <= (mem & ~loc_sel) | ({NLOC{wdata}} & loc_sel);
            else if (lat_wr)
                mem <= (mem & ~loc_sel) | ({NLOC{lat}} & loc_sel);
            if (lat_cap)
                lat <= lat_const ? lat_val : rd_bit;
        end
    end

    AST_ONE_PLANE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en && (wr_en || lat_wr)) |=> ($countones(mem ^ $past(mem)) <= 1)); // R1
    AST_IDLE_CELL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !row_en |=> $stable(mem)); // R6
endmodule

// File: rtl/pixmem_ctrl.sv
// Command sequencer: accepts one command, steps rows, drives array-wide strobes.
// Assumes: one command at a time; image transfers walk rows 0..ROWS-1, one per cycle.
module pixmem_ctrl
    import pixmem_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int RW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [LW-1:0]   cmd_loc,
    input  logic [1:0]      cmd_src,
    input  logic [RW-1:0]   cmd_row,
    input  logic [3:0]      cmd_lut,
    output logic            cmd_ready,
    output logic            done,
    output logic [ROWS-1:0] row_sel,
    output logic [LOCS-1:0] loc_sel,
    output logic            wr_en,
    output logic            lat_cap,
    output logic            lat_wr,
    output logic            lat_const,
    output logic            lat_val,
    output pm_src_e         src,
    output logic [3:0]      lut,
    output logic            col_oe
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    logic          busy;
    logic          all_q;
    pm_op_e        op_q;
    pm_op_e        op_in;
    logic [LW-1:0] loc_q;
    logic [1:0]    src_q;
    logic [RW-1:0] row_q;
    logic          img_op;

    assign op_in  = pm_op_e'(cmd_op);
    assign img_op = (op_q == OP_IMG_LOAD) || (op_q == OP_IMG_READ);

    // Accept a command, step the row counter, and pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            all_q <= 1'b0;
            op_q  <= OP_NOP;
            loc_q <= '0;
            src_q <= '0;
            lut   <= '0;
            row_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (cmd_valid) begin
                    busy  <= 1'b1;
                    op_q  <= op_in;
                    loc_q <= cmd_loc;
                    src_q <= cmd_src;
                    lut   <= cmd_lut;
                    row_q <= (op_in == OP_ROW_LOAD || op_in == OP_ROW_READ) ? cmd_row : '0;
                    all_q <= (op_in == OP_PAR_WRITE) || (op_in == OP_LATCH) ||
                             (op_in == OP_LATCH_WR);
                end
            end else if (img_op && row_q != LAST_ROW) begin
                row_q <= row_q + 1'b1;
            end else begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // Row decoder, with an all-rows mode for parallel operations.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_sel[r] = busy && (all_q || row_q == RW'(r));
    end

    // One-hot plane select.
    for (genvar l = 0; l < LOCS; l++) begin : g_loc
        assign loc_sel[l] = (loc_q == LW'(l));
    end

    // Array-wide strobes, derived from the active operation.
    always_comb begin
        cmd_ready = !busy;
        wr_en     = busy && (op_q == OP_IMG_LOAD || op_q == OP_ROW_LOAD || op_q == OP_PAR_WRITE);
        lat_cap   = busy && (op_q == OP_LATCH);
        lat_wr    = busy && (op_q == OP_LATCH_WR);
        lat_const = src_q[1];
        lat_val   = src_q[0];
        src       = (op_q == OP_PAR_WRITE) ? pm_src_e'(src_q) : SRC_COL;
        col_oe    = busy && (op_q == OP_IMG_READ || op_q == OP_ROW_READ);
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_FOLLOWS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && cmd_ready)); // R3
    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        col_oe |-> !(wr_en || lat_wr || lat_cap)); // R10
endmodule

// File: rtl/pixmem_array.sv
// Top: ROWS x COLS cells, the command sequencer, and the shared column-line read mux.
// Assumes: at most one row is selected while the array drives the column lines.
module pixmem_array
    import pixmem_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int NCELL = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [1:0]       cmd_loc,
    input  logic [1:0]       cmd_src,
    input  logic [RW-1:0]    cmd_row,
    input  logic [3:0]       cmd_lut,
    input  logic [COLS-1:0]  col_in,
    output logic [COLS-1:0]  col_out,
    output logic             col_oe,
    input  logic [NCELL-1:0] opt_in,
    input  logic [NCELL-1:0] evo_in,
    output logic             done
);
    logic [ROWS-1:0]  row_sel;
    logic [LOCS-1:0]  loc_sel;
    logic             wr_en, lat_cap, lat_wr, lat_const, lat_val;
    pm_src_e          src;
    logic [3:0]       lut;
    logic [NCELL-1:0] rd;

    // Sequencer instance.
    pixmem_ctrl #(.ROWS(ROWS), .RW(RW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_loc(cmd_loc), .cmd_src(cmd_src), .cmd_row(cmd_row), .cmd_lut(cmd_lut),
        .cmd_ready(cmd_ready), .done(done), .row_sel(row_sel), .loc_sel(loc_sel),
        .wr_en(wr_en), .lat_cap(lat_cap), .lat_wr(lat_wr), .lat_const(lat_const),
        .lat_val(lat_val), .src(src), .lut(lut), .col_oe(col_oe)
    );

    // The cell grid.
    for (genvar r = 0; r < ROWS; r++) begin : g_r
        for (genvar c = 0; c < COLS; c++) begin : g_c
            pixmem_cell #(.NLOC(LOCS)) u_cell (
                .clk(clk), .rst_n(rst_n), .row_en(row_sel[r]), .wr_en(wr_en),
                .lat_cap(lat_cap), .lat_wr(lat_wr), .loc_sel(loc_sel), .src(src),
                .lat_const(lat_const), .lat_val(lat_val), .lut(lut),
                .opt_bit(opt_in[r*COLS+c]), .evo_bit(evo_in[r*COLS+c]),
                .col_bit(col_in[c]), .rd_bit(rd[r*COLS+c])
            );
        end
    end

    // Column read mux: OR of the selected rows, driven only while reading.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [ROWS-1:0] hits;
        for (genvar r = 0; r < ROWS; r++) begin : g_hit
            assign hits[r] = row_sel[r] & rd[r*COLS+c];
        end
        assign col_out[c] = col_oe & (|hits);
    end

    AST_READ_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        col_oe |-> $onehot0(row_sel)); // R5
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !col_oe); // R10
endmodule

// File: tb/tb_pixmem_array.sv
`timescale 1ns/1ps
module tb_pixmem_array;
    localparam int ROWS = 5;
    localparam int COLS = 3;
    localparam int RW   = 3;
    localparam int N    = ROWS * COLS;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, cmd_valid, cmd_ready, col_oe, done;
    logic [2:0] cmd_op;
    logic [1:0] cmd_loc, cmd_src;
    logic [RW-1:0] cmd_row;
    logic [3:0] cmd_lut;
    logic [COLS-1:0] col_in, col_out;
    logic [N-1:0] opt_in, evo_in;

    pixmem_array #(.ROWS(ROWS), .COLS(COLS)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_loc(cmd_loc), .cmd_src(cmd_src), .cmd_row(cmd_row),
        .cmd_lut(cmd_lut), .col_in(col_in), .col_out(col_out), .col_oe(col_oe),
        .opt_in(opt_in), .evo_in(evo_in), .done(done)
    );

    // Behavioural model state.
    bit mdl [ROWS][COLS][4];
    bit lat_m [ROWS][COLS];
    int compared = 0, mismatched = 0;
    logic exp_ready, exp_done, exp_oe;
    logic [COLS-1:0] exp_out;
    string tag = "R2";
    bit mon_on = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) if (mon_on) begin
        chk("cmd_ready", 32'(cmd_ready), 32'(exp_ready));
        chk("done", 32'(done), 32'(exp_done));
        chk("col_oe", 32'(col_oe), 32'(exp_oe));
        chk("col_out", 32'(col_out), 32'(exp_out));
    end

    function automatic bit pat(int s, int r, int c);
        return ((r * 5 + c * 3 + s) % 4) < 2;
    endfunction

    // Issue one command, track expectations, and update the model.
    task automatic run(string t, int op, int loc, int src, int row, logic [3:0] lut, int seed);
        int nx;
        @(negedge clk);
        tag = t;
        cmd_op = 3'(op); cmd_loc = 2'(loc); cmd_src = 2'(src);
        cmd_row = RW'(row); cmd_lut = lut; cmd_valid = 1'b1;
        @(posedge clk); #1;
        cmd_valid = 1'b0; exp_ready = 1'b0; exp_done = 1'b0;
        nx = (op <= 1) ? ROWS : 1;
        for (int k = 0; k < nx; k++) begin
            int r;
            r = (op <= 1) ? k : ((op == 2 || op == 3) ? row : -1);
            for (int c = 0; c < COLS; c++) col_in[c] = pat(seed, (r < 0) ? 0 : r, c);
            exp_oe = (op == 1 || op == 3);
            exp_out = '0;
            if (exp_oe && r >= 0 && r < ROWS)
                for (int c = 0; c < COLS; c++) exp_out[c] = mdl[r][c][loc];
            @(posedge clk);
            if ((op == 0 || op == 2) && r >= 0 && r < ROWS)
                for (int c = 0; c < COLS; c++) mdl[r][c][loc] = col_in[c];
            for (int rr = 0; rr < ROWS; rr++)
                for (int c = 0; c < COLS; c++) begin
                    if (op == 4) begin
                        case (src)
                            0: mdl[rr][c][loc] = opt_in[rr*COLS+c];
                            1: mdl[rr][c][loc] = col_in[c];
                            2: mdl[rr][c][loc] = evo_in[rr*COLS+c];
                            default: mdl[rr][c][loc] = lut[{mdl[rr][c][1], mdl[rr][c][0]}];
                        endcase
                    end else if (op == 5) begin
                        lat_m[rr][c] = src[1] ? src[0] : mdl[rr][c][loc];
                    end else if (op == 6) begin
                        mdl[rr][c][loc] = lat_m[rr][c];
                    end
                end
            #1;
        end
        exp_ready = 1'b1; exp_done = 1'b1; exp_oe = 1'b0; exp_out = '0;
        @(posedge clk); #1;
        exp_done = 1'b0;
    endtask

    task automatic read_all(string t);
        for (int l = 0; l < 4; l++) run(t, 1, l, 0, 0, 4'h0, 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL R3 watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_loc = '0; cmd_src = '0;
        cmd_row = '0; cmd_lut = '0; col_in = '0;
        for (int i = 0; i < N; i++) begin
            opt_in[i] = (i % 3 == 0);
            evo_in[i] = (i % 2 == 1);
        end
        exp_ready = 1'b1; exp_done = 1'b0; exp_oe = 1'b0; exp_out = '0;
        repeat (3) @(posedge clk);
        #1 mon_on = 1;                         // R2: reset outputs
        @(negedge clk); rst_n = 1'b1;
        read_all("R2");                        // R2: planes clear after reset
        run("R4", 0, 2, 0, 0, 4'h0, 1);        // R4: image load into plane 2
        run("R5", 1, 2, 0, 0, 4'h0, 0);        // R5: image read of plane 2
        read_all("R1");                        // R1: other planes untouched
        run("R6", 2, 0, 0, 3, 4'h0, 2);        // R6: single row load
        run("R6", 3, 0, 0, 3, 4'h0, 0);        // R6: single row read
        run("R6", 2, 1, 0, 6, 4'h0, 3);        // R6: row index beyond ROWS
        run("R6", 3, 2, 0, 7, 4'h0, 0);        // R6: out-of-range read yields 0
        read_all("R6");
        run("R7", 4, 1, 0, 0, 4'h0, 0);        // R7: optical source
        run("R7", 4, 3, 2, 0, 4'h0, 0);        // R7: evolution source
        run("R7", 4, 0, 1, 0, 4'h0, 5);        // R7: column source, all rows
        read_all("R7");
        run("R8", 4, 2, 3, 0, 4'b0110, 0);     // R8: gate as XOR
        run("R8", 4, 3, 3, 0, 4'b1000, 0);     // R8: gate as AND
        run("R8", 4, 0, 3, 0, 4'b0111, 0);     // R8: gate writes its own input plane
        read_all("R8");
        run("R9", 5, 0, 3, 0, 4'h0, 0);        // R9: latch +1
        run("R9", 6, 3, 0, 0, 4'h0, 0);
        run("R9", 5, 2, 0, 0, 4'h0, 0);        // R9: copy plane 2 to plane 1
        run("R9", 6, 1, 0, 0, 4'h0, 0);
        run("R9", 5, 0, 2, 0, 4'h0, 0);        // R9: latch -1
        run("R9", 6, 2, 0, 0, 4'h0, 0);
        read_all("R9");
        run("R11", 7, 1, 1, 2, 4'hF, 6);       // R11: op 7 changes nothing
        read_all("R11");
        run("R10", 3, 1, 0, 4, 4'h0, 7);       // R10: reads do not modify
        read_all("R10");
        run("R3", 0, 3, 0, 0, 4'h0, 9);        // R3: back-to-back commands
        run("R3", 4, 1, 3, 0, 4'b1001, 0);
        read_all("R3");
        @(negedge clk);
        summary();
    end
endmodule